// File: doc/BRIEF.md
# Banked Working-Register and Stack Scratchpad

This block is the 128-byte on-chip scratch memory of a small 8-bit controller core. Each cycle it serves one operation chosen by a 4-bit code. The operation can be a byte access by absolute address, an access to one of eight working registers, an access through a pointer held in one of the first two working registers, a single-bit read or write, or a stack push or pop. The working registers are not fixed storage. Two bits of the status word place them in one of four eight-byte windows at the bottom of the memory.

The stack pointer lives inside the block. It is also visible at absolute address 81h. Every other absolute address from 80h upward is passed to a separate special-register port, together with its strobe and data. Read data, the bit result and the range-error flag are combinational in the cycle of the operation. All writes take effect at the next rising clock edge.

Top module: `banked_iram`

## Requirements
- R1: Absolute addresses 00h–7Fh select a RAM byte. `rdata` shows the addressed byte in the same cycle, before any write of that cycle lands. A direct write (op 2) is read back by a direct read (op 1).
- R2: A direct access to any address from 80h upward except 81h goes to the special-register port. `sfr_sel` is high, `sfr_addr` equals `addr` and `sfr_wdata` equals `wdata`. `sfr_we` is high only for op 2, `rdata` equals `sfr_rdata`, and no RAM byte changes.
- R3: Register ops (3 read, 4 write) use `addr[2:0]` as register n. They reach RAM byte `psw[4:3]*8 + n`.
- R4: Pointer ops (5 read, 6 write) take register R0 (`addr[0]`=0) or R1 (`addr[0]`=1) of the current window as a byte address below 80h, and access that byte.
- R5: A pointer value of 80h or more gives `rdata` 00h and raises `ind_err` in that cycle. A write in that case changes no byte.
- R6: Bit ops (7 read, 8 write) with a bit address b below 80h use byte `20h + b[6:3]` and bit `b[2:0]`. `rbit` returns that bit, and a write changes only that bit. A bit address of 80h or more gives `rbit` 0 and changes nothing.
- R7: Reset (`rst_n` low) sets the stack pointer to 07h and clears every RAM byte to 00h.
- R8: Push (op 9) raises the stack pointer by one and writes `wdata` at the new value, so the first push after reset lands at 08h.
- R9: Pop (op 10) returns the byte at the stack pointer in the same cycle, then lowers the pointer by one.
- R10: The stack pointer wraps modulo 256. A push whose target is 80h or more writes nothing. A pop at a pointer of 80h or more returns 00h. Both raise `ind_err`.
- R11: Direct address 81h reads the stack pointer, and op 2 loads it. That access does not reach the special-register port.
- R12: Op 0 is idle: no write, `sfr_sel` low, `rdata` 00h, `ind_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code (see R1–R12) |
| addr | input | 8 | Direct, register, pointer-select or bit address |
| wdata | input | 8 | Byte write data, push data |
| wbit | input | 1 | Bit write value |
| psw | input | 8 | Status word; bits 4:3 choose the register window |
| sfr_rdata | input | 8 | Read data returned by the special-register port |
| rdata | output | 8 | Read data of the current operation |
| rbit | output | 1 | Bit read result |
| sp | output | 8 | Current stack pointer |
| ind_err | output | 1 | Pointer or stack address out of RAM range |
| sfr_sel | output | 1 | Special-register access this cycle |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_addr | output | 8 | Special-register address |
| sfr_wdata | output | 8 | Special-register write data |

## Verification
The assertions assume that `op` carries one of the eleven defined codes and that the inputs are steady around each rising edge. The stack-pointer properties also assume that an operation lasts exactly one cycle. The bench changes its inputs only on falling edges and uses only the defined codes. It drives pointer values and stack positions on both sides of the 80h boundary, but always with a legal code.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_DIR_RD = 4'd1,
    OP_DIR_WR = 4'd2,
    OP_REG_RD = 4'd3,
    OP_REG_WR = 4'd4,
    OP_IND_RD = 4'd5,
    OP_IND_WR = 4'd6,
    OP_BIT_RD = 4'd7,
    OP_BIT_WR = 4'd8,
    OP_PUSH   = 4'd9,
    OP_POP    = 4'd10
  } iram_op_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_SFR  = 2'd2,
    TGT_SP   = 2'd3
  } iram_tgt_e;

  // first byte of a register window
  function automatic logic [7:0] window_base(input logic [1:0] bank);
    return {3'b000, bank, 3'b000};
  endfunction

  // byte holding a bit of the bit-addressable area
  function automatic logic [7:0] bit_home(input logic [7:0] area, input logic [3:0] idx);
    return area + {4'b0000, idx};
  endfunction

  function automatic logic [7:0] bit_select(input logic [2:0] pos);
    return 8'd1 << pos;
  endfunction

  function automatic logic [7:0] sp_inc(input logic [7:0] v);
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] sp_dec(input logic [7:0] v);
    return v - 8'd1;
  endfunction

  function automatic logic op_writes(input iram_op_e o);
    return (o == OP_DIR_WR) || (o == OP_REG_WR) || (o == OP_IND_WR) ||
           (o == OP_BIT_WR) || (o == OP_PUSH);
  endfunction

endpackage

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr_addr,
  output logic [7:0]    ptr_data,
  input  logic [AW-1:0] acc_addr,
  output logic [7:0]    acc_data,
  input  logic          we,
  input  logic [7:0]    wr_mask,
  input  logic [7:0]    wr_data
);

  logic [7:0] mem [DEPTH];

  assign ptr_data = mem[ptr_addr];
  assign acc_data = mem[acc_addr];

  // masked read-modify-write: a byte write uses an all-ones mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[acc_addr] <= (mem[acc_addr] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  assert_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_mask != 8'h00));

endmodule

// File: rtl/iram_sp.sv
module iram_sp
  import iram_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] sp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= RESET_VAL;
    else if (load)  sp <= load_val;
    else if (push)  sp <= sp_inc(sp);
    else if (pop)   sp <= sp_dec(sp);
  end

  assert_push_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == 8'($past(sp) + 8'd1)));

  assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (sp == 8'($past(sp) - 8'd1)));

  assert_sp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push || pop || load) |=> $stable(sp));

  assert_single_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop, load}));

endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter logic [7:0] BIT_AREA = 8'h20,
  parameter logic [7:0] SP_ADDR  = 8'h81
) (
  input  iram_op_e   op,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  input  logic [7:0] ptr_val,
  input  logic [7:0] sp,
  output iram_tgt_e  tgt,
  output logic [7:0] byte_addr,
  output logic [7:0] mask,
  output logic [2:0] bit_pos,
  output logic       is_bit,
  output logic       range_err
);

  logic [7:0] push_target;
  assign push_target = sp_inc(sp);

  always_comb begin
    tgt       = TGT_NONE;
    byte_addr = 8'h00;
    mask      = 8'hFF;
    bit_pos   = addr[2:0];
    is_bit    = 1'b0;
    range_err = 1'b0;
    unique case (op)
      OP_DIR_RD, OP_DIR_WR: begin
        byte_addr = addr;
        if (!addr[7])             tgt = TGT_RAM;
        else if (addr == SP_ADDR) tgt = TGT_SP;
        else                      tgt = TGT_SFR;
      end
      OP_REG_RD, OP_REG_WR: begin
        tgt       = TGT_RAM;
        byte_addr = window_base(bank) | {5'b00000, addr[2:0]};
      end
      OP_IND_RD, OP_IND_WR: begin
        byte_addr = ptr_val;
        if (ptr_val[7]) range_err = 1'b1;
        else            tgt       = TGT_RAM;
      end
      OP_BIT_RD, OP_BIT_WR: begin
        is_bit    = 1'b1;
        byte_addr = bit_home(BIT_AREA, addr[6:3]);
        mask      = bit_select(addr[2:0]);
        if (!addr[7]) tgt = TGT_RAM;
      end
      OP_PUSH: begin
        byte_addr = push_target;
        if (push_target[7]) range_err = 1'b1;
        else                tgt       = TGT_RAM;
      end
      OP_POP: begin
        byte_addr = sp;
        if (sp[7]) range_err = 1'b1;
        else       tgt       = TGT_RAM;
      end
      default: ;
    endcase
  end

  // every RAM target must lie in the lower half of the address space
  always_comb begin
    assert_ram_low_R1: assert (tgt != TGT_RAM || !byte_addr[7]);
  end

endmodule

// File: rtl/banked_iram.sv
module banked_iram
  import iram_pkg::*;
#(
  parameter int         RAM_BYTES = 128,
  parameter int         BANK_LSB  = 3,
  parameter logic [7:0] BIT_AREA  = 8'h20,
  parameter logic [7:0] SP_ADDR   = 8'h81,
  parameter logic [7:0] SP_RESET  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wbit,
  input  logic [7:0] psw,
  input  logic [7:0] sfr_rdata,
  output logic [7:0] rdata,
  output logic       rbit,
  output logic [7:0] sp,
  output logic       ind_err,
  output logic       sfr_sel,
  output logic       sfr_we,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata
);

  localparam int AW = $clog2(RAM_BYTES);

  iram_op_e   op_e;
  iram_tgt_e  tgt;
  logic [1:0] bank;
  logic [7:0] ptr_val, acc_val, byte_addr, mask, wr_val;
  logic [2:0] bit_pos;
  logic       is_bit, wr_op;
  logic       ram_we, sp_push, sp_pop, sp_load;
  logic [AW-1:0] ptr_addr;
  logic       unused_bits;

  assign op_e     = iram_op_e'(op);
  assign bank     = psw[BANK_LSB+1:BANK_LSB];
  assign ptr_addr = AW'(window_base(bank) | {7'b0000000, addr[0]});
  assign wr_op    = op_writes(op_e);

  iram_addr_map #(.BIT_AREA(BIT_AREA), .SP_ADDR(SP_ADDR)) u_map (
    .op(op_e), .addr(addr), .bank(bank), .ptr_val(ptr_val), .sp(sp),
    .tgt(tgt), .byte_addr(byte_addr), .mask(mask), .bit_pos(bit_pos),
    .is_bit(is_bit), .range_err(ind_err)
  );

  // named events used by the assertions below
  assign ram_we  = (tgt == TGT_RAM) && wr_op;
  assign sp_load = (tgt == TGT_SP) && wr_op;
  assign sp_push = (op_e == OP_PUSH);
  assign sp_pop  = (op_e == OP_POP);
  assign wr_val  = is_bit ? {8{wbit}} : wdata;

  iram_store #(.DEPTH(RAM_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ptr_addr(ptr_addr), .ptr_data(ptr_val),
    .acc_addr(byte_addr[AW-1:0]), .acc_data(acc_val),
    .we(ram_we), .wr_mask(mask), .wr_data(wr_val)
  );

  iram_sp #(.RESET_VAL(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(sp_push), .pop(sp_pop),
    .load(sp_load), .load_val(wdata), .sp(sp)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM: rdata = acc_val;
      TGT_SFR: rdata = sfr_rdata;
      TGT_SP:  rdata = sp;
      default: rdata = 8'h00;
    endcase
  end

  assign rbit      = (tgt == TGT_RAM) && is_bit && acc_val[bit_pos];
  assign sfr_sel   = (tgt == TGT_SFR);
  assign sfr_we    = sfr_sel && wr_op;
  assign sfr_addr  = addr;
  assign sfr_wdata = wdata;

  assign unused_bits = ^{psw, byte_addr[7:AW]};

  assert_err_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ind_err |-> !ram_we && (rdata == 8'h00));

  assert_sfr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> !ram_we && !sp_load);

  assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ind_err |-> (op_e == OP_IND_RD || op_e == OP_IND_WR || sp_push || sp_pop));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_IDLE) |=> $stable(sp));

endmodule

// File: tb/test_banked_iram.sv
module test_banked_iram;

  localparam logic [3:0] C_IDLE = 4'd0, C_DRD = 4'd1, C_DWR = 4'd2, C_RRD = 4'd3,
                         C_RWR = 4'd4, C_IRD = 4'd5, C_IWR = 4'd6, C_BRD = 4'd7,
                         C_BWR = 4'd8, C_PSH = 4'd9, C_POP = 4'd10;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       wbit;
    logic [7:0] psw;
    logic [7:0] exp_rd;
    logic       exp_bit;
    logic       exp_err;
    logic [7:0] exp_sp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  // op, addr, wdata, wbit, psw, rdata, rbit, err, sp-in-cycle, requirement
  localparam vec_t VEC [NV] = '{
    '{C_DWR, 8'h30, 8'hA5, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd1},  // R1
    '{C_DRD, 8'h30, 8'h00, 1'b0, 8'h00, 8'hA5, 1'b0, 1'b0, 8'h07, 4'd1},  // R1
    '{C_RWR, 8'h03, 8'h3C, 1'b0, 8'h08, 8'h00, 1'b0, 1'b0, 8'h07, 4'd3},  // R3 window 1
    '{C_DRD, 8'h0B, 8'h00, 1'b0, 8'h00, 8'h3C, 1'b0, 1'b0, 8'h07, 4'd3},  // R3
    '{C_RRD, 8'h03, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd3},  // R3 window 0
    '{C_RRD, 8'h03, 8'h00, 1'b0, 8'h08, 8'h3C, 1'b0, 1'b0, 8'h07, 4'd3},  // R3
    '{C_RWR, 8'h00, 8'h40, 1'b0, 8'h18, 8'h00, 1'b0, 1'b0, 8'h07, 4'd3},  // R3 window 3
    '{C_IWR, 8'h00, 8'h77, 1'b0, 8'h18, 8'h00, 1'b0, 1'b0, 8'h07, 4'd4},  // R4 via R0
    '{C_DRD, 8'h40, 8'h00, 1'b0, 8'h00, 8'h77, 1'b0, 1'b0, 8'h07, 4'd4},  // R4
    '{C_RWR, 8'h01, 8'h90, 1'b0, 8'h18, 8'h00, 1'b0, 1'b0, 8'h07, 4'd4},  // R4 set R1
    '{C_IRD, 8'h01, 8'h00, 1'b0, 8'h18, 8'h00, 1'b0, 1'b1, 8'h07, 4'd5},  // R5
    '{C_IWR, 8'h01, 8'hFF, 1'b0, 8'h18, 8'h00, 1'b0, 1'b1, 8'h07, 4'd5},  // R5
    '{C_DRD, 8'h10, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd5},  // R5 no alias
    '{C_BWR, 8'h0B, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_DRD, 8'h21, 8'h00, 1'b0, 8'h00, 8'h08, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_BRD, 8'h0B, 8'h00, 1'b0, 8'h00, 8'h08, 1'b1, 1'b0, 8'h07, 4'd6},  // R6
    '{C_BRD, 8'h0A, 8'h00, 1'b0, 8'h00, 8'h08, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_DWR, 8'h2F, 8'hF0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_BWR, 8'h7C, 8'h00, 1'b0, 8'h00, 8'hF0, 1'b1, 1'b0, 8'h07, 4'd6},  // R6 clear
    '{C_DRD, 8'h2F, 8'h00, 1'b0, 8'h00, 8'hE0, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_BWR, 8'h85, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd6},  // R6 high bit addr
    '{C_DRD, 8'h20, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd6},  // R6
    '{C_DWR, 8'h90, 8'h12, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h07, 4'd2},  // R2
    '{C_DRD, 8'h81, 8'h00, 1'b0, 8'h00, 8'h07, 1'b0, 1'b0, 8'h07, 4'd11}, // R11
    '{C_PSH, 8'h00, 8'hC3, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h07, 4'd8},  // R8
    '{C_DRD, 8'h08, 8'h00, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0, 8'h08, 4'd8},  // R8
    '{C_PSH, 8'h00, 8'hD4, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h08, 4'd8},  // R8
    '{C_POP, 8'h00, 8'h00, 1'b0, 8'h00, 8'hD4, 1'b0, 1'b0, 8'h09, 4'd9},  // R9
    '{C_POP, 8'h00, 8'h00, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0, 8'h08, 4'd9},  // R9
    '{C_DRD, 8'h81, 8'h00, 1'b0, 8'h00, 8'h07, 1'b0, 1'b0, 8'h07, 4'd9}   // R9
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, psw = 8'h00, sfr_rdata = 8'h5A;
  logic       wbit = 1'b0;
  logic [7:0] rdata, sp, sfr_addr, sfr_wdata;
  logic       rbit, ind_err, sfr_sel, sfr_we;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  banked_iram i_banked_iram (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata), .wbit(wbit),
    .psw(psw), .sfr_rdata(sfr_rdata), .rdata(rdata), .rbit(rbit), .sp(sp),
    .ind_err(ind_err), .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive on the falling edge, settle, outputs are then valid for this op
  task automatic issue(input logic [3:0] o, input logic [7:0] a, input logic [7:0] d,
                       input logic b, input logic [7:0] p);
    @(negedge clk);
    op = o; addr = a; wdata = d; wbit = b; psw = p;
    #5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    issue(C_DRD, 8'h81, 8'h00, 1'b0, 8'h00);
    chk("R7 sp after reset", sp, 8'h07);
    chk("R7 sp via 81h", rdata, 8'h07);
    issue(C_DRD, 8'h7F, 8'h00, 1'b0, 8'h00);
    chk("R7 RAM cleared", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].wbit, VEC[i].psw);
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rdata, VEC[i].exp_rd);
      chk($sformatf("R%0d vec %0d rbit", VEC[i].req, i), {7'd0, rbit}, {7'd0, VEC[i].exp_bit});
      chk($sformatf("R%0d vec %0d err", VEC[i].req, i), {7'd0, ind_err}, {7'd0, VEC[i].exp_err});
      chk($sformatf("R%0d vec %0d sp", VEC[i].req, i), sp, VEC[i].exp_sp);
    end

    // R2 special-register port strobes
    issue(C_DWR, 8'h90, 8'h12, 1'b0, 8'h00);
    chk("R2 sel", {7'd0, sfr_sel}, 8'd1);
    chk("R2 we", {7'd0, sfr_we}, 8'd1);
    chk("R2 addr", sfr_addr, 8'h90);
    chk("R2 wdata", sfr_wdata, 8'h12);
    issue(C_DRD, 8'hA0, 8'h00, 1'b0, 8'h00);
    chk("R2 read no we", {7'd0, sfr_we}, 8'd0);
    chk("R2 read data", rdata, 8'h5A);

    // R11 stack pointer load stays local; R10 boundary and wrap
    issue(C_DWR, 8'h81, 8'h7F, 1'b0, 8'h00);
    chk("R11 no sfr_sel", {7'd0, sfr_sel}, 8'd0);
    issue(C_PSH, 8'h00, 8'hEE, 1'b0, 8'h00);
    chk("R11 sp loaded", sp, 8'h7F);
    chk("R10 push past RAM err", {7'd0, ind_err}, 8'd1);
    issue(C_POP, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R10 sp 80h", sp, 8'h80);
    chk("R10 pop high err", {7'd0, ind_err}, 8'd1);
    chk("R10 pop high data", rdata, 8'h00);
    issue(C_DRD, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R10 sp back 7Fh", sp, 8'h7F);
    chk("R10 ignored push left 00h", rdata, 8'h00);
    issue(C_DWR, 8'h81, 8'hFF, 1'b0, 8'h00);
    issue(C_PSH, 8'h00, 8'h5E, 1'b0, 8'h00);
    chk("R10 push no err", {7'd0, ind_err}, 8'd0);
    issue(C_DRD, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R10 sp wrapped to 00h", sp, 8'h00);
    chk("R10 wrapped push data", rdata, 8'h5E);
    issue(C_POP, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R9 pop at 00h", rdata, 8'h5E);
    issue(C_IDLE, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R10 sp wrapped to FFh", sp, 8'hFF);

    // R12 idle op
    issue(C_IDLE, 8'h90, 8'h33, 1'b1, 8'h18);
    chk("R12 idle rdata", rdata, 8'h00);
    chk("R12 idle sfr_sel", {7'd0, sfr_sel}, 8'd0);
    chk("R12 idle err", {7'd0, ind_err}, 8'd0);
    issue(C_DRD, 8'h81, 8'h00, 1'b0, 8'h00);
    chk("R12 idle sp unchanged", rdata, 8'hFF);

    // R7 reset during operation
    issue(C_DWR, 8'h30, 8'h99, 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    op = C_IDLE;
    @(negedge clk);
    rst_n = 1'b1;
    issue(C_DRD, 8'h30, 8'h00, 1'b0, 8'h00);
    chk("R7 RAM cleared by reset", rdata, 8'h00);
    chk("R7 sp reloaded", sp, 8'h07);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule